// File: doc/BRIEF.md
# Secure Region Address Overlay Controller

This block sits between a flash command decoder and the flash array. It decides whether accesses go to the normal boot sectors or to a small one-time-programmable identification region that overlays them. That region is 256 bytes long. Its lowest part holds a random serial number. The rest is user code, which reads as all ones when erased. The decoder delivers single-cycle enter and exit pulses. The block holds the overlay mode until one of three things happens: an exit is accepted, the hardware reset input is pulsed, or the power-on reset is applied.

While the overlay is active, the block turns the incoming address into a region offset. In word mode that offset is a 16-bit-word index. In byte mode it is a byte index. Addresses wrap modulo the region size. The block also flags offsets that fall inside the serial-number field.

A factory-lock strap is sampled only during power-on reset. The sampled value is then reported as a read-only indicator. When that indicator is set, the block refuses program and erase requests that target the region and emits a single-cycle reject pulse.

Top module: `sro_overlay_ctrl`

## Requirements
- R1: During and directly after power-on reset (`rst`), `region_sel_o` and `wr_reject_o` are 0, and `lock_ind_o` equals the value of `lock_fuse_i` at the last reset cycle.
- R2: A cycle with `enter_i`=1, `exit_i`=0 and `hw_reset_i`=0 sets `region_sel_o` to 1 from the next clock edge. It then stays 1 through idle cycles and further enter pulses.
- R3: A cycle with `exit_i`=1 clears `region_sel_o` to 0 at the next clock edge.
- R4: When `enter_i` and `exit_i` are both 1 in the same cycle, exit takes effect: `region_sel_o` is 0 after that edge, whether or not the overlay was active before.
- R5: A cycle with `hw_reset_i`=1 clears `region_sel_o` at the next edge, even if `enter_i` is also 1.
- R6: In word mode (`word_mode_i`=1) with the overlay active, `region_ofs_o` equals `addr_i` modulo 128, and `serial_fld_o` is 1 exactly when that offset is 0x00 to 0x07.
- R7: In byte mode (`word_mode_i`=0) with the overlay active, `region_ofs_o` equals `addr_i` modulo 256, and `serial_fld_o` is 1 exactly when that offset is 0x00 to 0x0F.
- R8: While the overlay is inactive, `region_ofs_o` is 0 and `serial_fld_o` is 0 for every address.
- R9: With `lock_ind_o`=1 and the overlay active, a program or erase request gives a 0 on its grant output in the same cycle. `wr_reject_o` is then 1 for exactly the following cycle.
- R10: With the overlay inactive, or with `lock_ind_o`=0, each grant output equals its request input and `wr_reject_o` stays 0.
- R11: No command changes `lock_ind_o` after reset. This covers enter, exit and hardware reset pulses, requests, and changes on `lock_fuse_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| lock_fuse_i | input | 1 | Factory-lock strap, sampled only during reset |
| enter_i | input | 1 | Decoded enter-overlay command pulse |
| exit_i | input | 1 | Decoded exit-overlay command pulse |
| hw_reset_i | input | 1 | Hardware reset pulse; leaves the overlay |
| word_mode_i | input | 1 | 1 = 16-bit word addressing, 0 = byte addressing |
| addr_i | input | ADDR_W (20) | Incoming array address |
| prog_req_i | input | 1 | Program request from the decoder |
| erase_req_i | input | 1 | Erase request from the decoder |
| region_sel_o | output | 1 | Overlay active: accesses go to the region |
| region_ofs_o | output | 8 | Translated region offset (0 when inactive) |
| serial_fld_o | output | 1 | Offset lies in the serial-number field |
| lock_ind_o | output | 1 | Read-only factory-lock indicator |
| prog_grant_o | output | 1 | Program request passed to the array |
| erase_grant_o | output | 1 | Erase request passed to the array |
| wr_reject_o | output | 1 | One-cycle pulse after a refused program/erase |

## Verification
The hardest situations to reach are the command collisions. These are enter together with exit, and enter together with hardware reset. Each has to be applied in both overlay states, because the overlay must already be active for the override to show. The bench first puts the block into region mode with a plain enter pulse, then applies the colliding pulses in one cycle. A second collision is applied from the inactive state.

The lock path has its own difficulty: the strap is captured only during power-on reset. To cover it, the bench runs two full reset episodes, one with the strap high and one with it low. Within each episode it toggles the strap and observes that the indicator and the reject behaviour do not move.

// File: rtl/sro_pkg.sv
package sro_pkg;

    localparam int unsigned SRO_REGION_BYTES = 256;
    localparam int unsigned SRO_SN_BYTES     = 16;
    localparam int unsigned SRO_ADDR_W       = 20;

    typedef enum logic {
        OVL_BOOT   = 1'b0,
        OVL_REGION = 1'b1
    } ovl_mode_e;

    typedef struct packed {
        logic enter;
        logic leave;
        logic hw_rst;
    } ovl_cmd_t;

    typedef struct packed {
        logic prog;
        logic erase;
    } wr_req_t;

    // Leaving has priority over entering; hardware reset behaves as a leave.
    function automatic ovl_mode_e next_mode(ovl_mode_e cur, ovl_cmd_t cmd);
        if (cmd.hw_rst || cmd.leave)
            return OVL_BOOT;
        else if (cmd.enter)
            return OVL_REGION;
        else
            return cur;
    endfunction

endpackage

// File: rtl/sro_mode_fsm.sv
module sro_mode_fsm
    import sro_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  ovl_cmd_t  cmd_i,
    output ovl_mode_e mode_o
);

    ovl_mode_e mode_q;

    always_ff @(posedge clk) begin
        if (rst)
            mode_q <= OVL_BOOT;
        else
            mode_q <= next_mode(mode_q, cmd_i);
    end

    assign mode_o = mode_q;

    assert_enter_sets_R2: assert property (@(posedge clk) disable iff (rst)
        (cmd_i.enter && !cmd_i.leave && !cmd_i.hw_rst) |=> (mode_o == OVL_REGION));

    assert_mode_sticky_R2: assert property (@(posedge clk) disable iff (rst)
        (mode_o == OVL_REGION && !cmd_i.leave && !cmd_i.hw_rst) |=> (mode_o == OVL_REGION));

    assert_exit_wins_R4: assert property (@(posedge clk) disable iff (rst)
        cmd_i.leave |=> (mode_o == OVL_BOOT));

    assert_hwreset_clears_R5: assert property (@(posedge clk) disable iff (rst)
        cmd_i.hw_rst |=> (mode_o == OVL_BOOT));

endmodule

// File: rtl/sro_addr_xlate.sv
module sro_addr_xlate #(
    parameter int unsigned ADDR_W       = 20,
    parameter int unsigned REGION_BYTES = 256,
    parameter int unsigned SN_BYTES     = 16,
    localparam int unsigned OFS_W       = $clog2(REGION_BYTES)
) (
    input  logic              in_region_i,
    input  logic              word_mode_i,
    input  logic [ADDR_W-1:0] addr_i,
    output logic [OFS_W-1:0]  ofs_o,
    output logic              sn_o
);

    localparam int unsigned WOFS_W   = OFS_W - 1;
    localparam int unsigned SN_WORDS = SN_BYTES / 2;
    localparam logic [OFS_W:0] SN_LIM_B = (OFS_W+1)'(SN_BYTES);
    localparam logic [OFS_W:0] SN_LIM_W = (OFS_W+1)'(SN_WORDS);

    logic [OFS_W-1:0] byte_ofs;
    logic [OFS_W-1:0] word_ofs;
    logic [OFS_W-1:0] pick_ofs;
    logic [OFS_W:0]   sn_lim;
    logic             unused_hi_addr;

    // Upper address bits fold away: the region wraps modulo its size.
    assign unused_hi_addr = ^addr_i[ADDR_W-1:OFS_W];

    always_comb begin
        byte_ofs = addr_i[OFS_W-1:0];
        word_ofs = {1'b0, addr_i[WOFS_W-1:0]};
        pick_ofs = word_mode_i ? word_ofs : byte_ofs;
        sn_lim   = word_mode_i ? SN_LIM_W : SN_LIM_B;
        ofs_o    = in_region_i ? pick_ofs : '0;
        sn_o     = in_region_i && ({1'b0, pick_ofs} < sn_lim);
    end

    always_comb begin
        assert_sn_needs_region_R8: assert (!sn_o || in_region_i);
    end

endmodule

// File: rtl/sro_lock_guard.sv
module sro_lock_guard
    import sro_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    fuse_i,
    input  logic    in_region_i,
    input  wr_req_t req_i,
    output wr_req_t grant_o,
    output logic    lock_o,
    output logic    reject_o
);

    logic locked_q;
    logic reject_q;
    logic blocked;

    // The strap is captured only while reset is held; nothing else writes it.
    always_ff @(posedge clk) begin
        if (rst)
            locked_q <= fuse_i;
    end

    assign blocked = in_region_i && locked_q;

    always_comb begin
        grant_o.prog  = req_i.prog  && !blocked;
        grant_o.erase = req_i.erase && !blocked;
    end

    always_ff @(posedge clk) begin
        if (rst)
            reject_q <= 1'b0;
        else
            reject_q <= blocked && (req_i.prog || req_i.erase);
    end

    assign lock_o   = locked_q;
    assign reject_o = reject_q;

    assert_reject_after_blocked_R9: assert property (@(posedge clk) disable iff (rst)
        ((req_i.prog || req_i.erase) && in_region_i && lock_o) |=> reject_o);

    assert_reject_has_cause_R10: assert property (@(posedge clk) disable iff (rst)
        reject_o |-> ($past(req_i.prog || req_i.erase) && $past(in_region_i) && lock_o));

    assert_lock_frozen_R11: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> $stable(lock_o));

endmodule

// File: rtl/sro_overlay_ctrl.sv
module sro_overlay_ctrl
    import sro_pkg::*;
#(
    parameter int unsigned ADDR_W       = SRO_ADDR_W,
    parameter int unsigned REGION_BYTES = SRO_REGION_BYTES,
    parameter int unsigned SN_BYTES     = SRO_SN_BYTES
) (
    input  logic                            clk,
    input  logic                            rst,
    input  logic                            lock_fuse_i,
    input  logic                            enter_i,
    input  logic                            exit_i,
    input  logic                            hw_reset_i,
    input  logic                            word_mode_i,
    input  logic [ADDR_W-1:0]               addr_i,
    input  logic                            prog_req_i,
    input  logic                            erase_req_i,
    output logic                            region_sel_o,
    output logic [$clog2(REGION_BYTES)-1:0] region_ofs_o,
    output logic                            serial_fld_o,
    output logic                            lock_ind_o,
    output logic                            prog_grant_o,
    output logic                            erase_grant_o,
    output logic                            wr_reject_o
);

    ovl_cmd_t  cmd;
    ovl_mode_e mode;
    wr_req_t   req;
    wr_req_t   grant;
    logic      in_region;

    assign cmd.enter  = enter_i;
    assign cmd.leave  = exit_i;
    assign cmd.hw_rst = hw_reset_i;

    assign req.prog  = prog_req_i;
    assign req.erase = erase_req_i;

    sro_mode_fsm u_mode (
        .clk    (clk),
        .rst    (rst),
        .cmd_i  (cmd),
        .mode_o (mode)
    );

    assign in_region = (mode == OVL_REGION);

    sro_addr_xlate #(
        .ADDR_W       (ADDR_W),
        .REGION_BYTES (REGION_BYTES),
        .SN_BYTES     (SN_BYTES)
    ) u_xlate (
        .in_region_i (in_region),
        .word_mode_i (word_mode_i),
        .addr_i      (addr_i),
        .ofs_o       (region_ofs_o),
        .sn_o        (serial_fld_o)
    );

    sro_lock_guard u_guard (
        .clk         (clk),
        .rst         (rst),
        .fuse_i      (lock_fuse_i),
        .in_region_i (in_region),
        .req_i       (req),
        .grant_o     (grant),
        .lock_o      (lock_ind_o),
        .reject_o    (wr_reject_o)
    );

    assign region_sel_o  = in_region;
    assign prog_grant_o  = grant.prog;
    assign erase_grant_o = grant.erase;

    assert_reset_state_R1: assert property (@(posedge clk)
        rst |=> (!region_sel_o && !wr_reject_o));

endmodule

// File: tb/sro_overlay_ctrl_bench.sv
module sro_overlay_ctrl_bench;

    logic        clk = 1'b0;
    logic        rst;
    logic        lock_fuse_i;
    logic        enter_i, exit_i, hw_reset_i;
    logic        word_mode_i;
    logic [19:0] addr_i;
    logic        prog_req_i, erase_req_i;
    logic        region_sel_o;
    logic [7:0]  region_ofs_o;
    logic        serial_fld_o, lock_ind_o;
    logic        prog_grant_o, erase_grant_o, wr_reject_o;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    sro_overlay_ctrl u_sro_overlay_ctrl (
        .clk          (clk),
        .rst          (rst),
        .lock_fuse_i  (lock_fuse_i),
        .enter_i      (enter_i),
        .exit_i       (exit_i),
        .hw_reset_i   (hw_reset_i),
        .word_mode_i  (word_mode_i),
        .addr_i       (addr_i),
        .prog_req_i   (prog_req_i),
        .erase_req_i  (erase_req_i),
        .region_sel_o (region_sel_o),
        .region_ofs_o (region_ofs_o),
        .serial_fld_o (serial_fld_o),
        .lock_ind_o   (lock_ind_o),
        .prog_grant_o (prog_grant_o),
        .erase_grant_o(erase_grant_o),
        .wr_reject_o  (wr_reject_o)
    );

    // {word_mode, addr, expected offset, expected serial flag}
    localparam int NVEC = 11;
    localparam logic [29:0] VEC [NVEC] = '{
        {1'b1, 20'h00000, 8'h00, 1'b1},
        {1'b1, 20'h00007, 8'h07, 1'b1},
        {1'b1, 20'h00008, 8'h08, 1'b0},
        {1'b1, 20'h0007F, 8'h7F, 1'b0},
        {1'b1, 20'h00080, 8'h00, 1'b1},
        {1'b1, 20'h12345, 8'h45, 1'b0},
        {1'b0, 20'h0000F, 8'h0F, 1'b1},
        {1'b0, 20'h00010, 8'h10, 1'b0},
        {1'b0, 20'h000FF, 8'hFF, 1'b0},
        {1'b0, 20'h00100, 8'h00, 1'b1},
        {1'b0, 20'hABC0A, 8'h0A, 1'b1}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic cyc();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic idle_inputs();
        enter_i = 0; exit_i = 0; hw_reset_i = 0;
        prog_req_i = 0; erase_req_i = 0;
    endtask

    task automatic do_reset(input logic fuse);
        rst = 1; lock_fuse_i = fuse;
        cyc(); cyc();
        check("R1 sel in reset", {31'b0, region_sel_o}, 0);
        rst = 0;
        cyc();
        check("R1 sel", {31'b0, region_sel_o}, 0);
        check("R1 reject", {31'b0, wr_reject_o}, 0);
        check("R1 lock", {31'b0, lock_ind_o}, {31'b0, fuse});
    endtask

    task automatic pulse_enter();
        enter_i = 1; cyc(); enter_i = 0;
    endtask

    initial begin
        #(20 * 20000);
        n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        idle_inputs();
        word_mode_i = 1; addr_i = '0;
        @(negedge clk);
        do_reset(1'b1);

        // R8: inactive overlay hides offset and serial flag
        addr_i = 20'h00003; #1;
        check("R8 ofs", {24'b0, region_ofs_o}, 0);
        check("R8 sn", {31'b0, serial_fld_o}, 0);
        // R10: not in region -> pass through, no reject
        prog_req_i = 1; #1;
        check("R10 grant boot", {31'b0, prog_grant_o}, 1);
        cyc(); prog_req_i = 0;
        check("R10 no reject boot", {31'b0, wr_reject_o}, 0);

        // R2: enter, then stays through idle
        lock_fuse_i = 0;
        pulse_enter();
        check("R2 enter", {31'b0, region_sel_o}, 1);
        cyc(); cyc(); pulse_enter(); cyc();
        check("R2 sticky", {31'b0, region_sel_o}, 1);
        check("R11 fuse change", {31'b0, lock_ind_o}, 1);

        // R6/R7 table walk
        for (int i = 0; i < NVEC; i++) begin
            word_mode_i = VEC[i][29];
            addr_i      = VEC[i][28:9];
            #1;
            check(VEC[i][29] ? "R6 ofs" : "R7 ofs", {24'b0, region_ofs_o}, {24'b0, VEC[i][8:1]});
            check(VEC[i][29] ? "R6 sn" : "R7 sn", {31'b0, serial_fld_o}, {31'b0, VEC[i][0]});
        end

        // R9: locked, in region, program then erase
        prog_req_i = 1; #1;
        check("R9 prog blocked", {31'b0, prog_grant_o}, 0);
        cyc(); prog_req_i = 0;
        check("R9 reject pulse", {31'b0, wr_reject_o}, 1);
        cyc();
        check("R9 reject one cycle", {31'b0, wr_reject_o}, 0);
        erase_req_i = 1; #1;
        check("R9 erase blocked", {31'b0, erase_grant_o}, 0);
        cyc(); erase_req_i = 0;
        check("R9 reject erase", {31'b0, wr_reject_o}, 1);
        cyc();
        check("R9 reject erase end", {31'b0, wr_reject_o}, 0);

        // R4: enter+exit while active, then while inactive
        enter_i = 1; exit_i = 1; cyc(); idle_inputs();
        check("R4 exit wins active", {31'b0, region_sel_o}, 0);
        enter_i = 1; exit_i = 1; cyc(); idle_inputs();
        check("R4 exit wins idle", {31'b0, region_sel_o}, 0);

        // R5: hardware reset overrides enter
        pulse_enter();
        hw_reset_i = 1; enter_i = 1; cyc(); idle_inputs();
        check("R5 hw reset", {31'b0, region_sel_o}, 0);
        check("R11 hw reset keeps lock", {31'b0, lock_ind_o}, 1);

        // R3: plain exit
        pulse_enter();
        exit_i = 1; cyc(); exit_i = 0;
        check("R3 exit", {31'b0, region_sel_o}, 0);

        // R1 again from active overlay, strap low
        pulse_enter();
        do_reset(1'b0);
        lock_fuse_i = 1;

        // R10: unlocked region passes requests
        pulse_enter();
        prog_req_i = 1; erase_req_i = 1; #1;
        check("R10 prog unlocked", {31'b0, prog_grant_o}, 1);
        check("R10 erase unlocked", {31'b0, erase_grant_o}, 1);
        cyc(); idle_inputs();
        check("R10 no reject unlocked", {31'b0, wr_reject_o}, 0);
        check("R11 lock stays low", {31'b0, lock_ind_o}, 0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule